// File: doc/BRIEF.md
# Flash Write Status Byte Generator

This block sits in the read path of a parallel NOR-style flash model. While an embedded program or erase runs, reads do not return stored data but a status byte. The byte carries a data-polling bit, a bit that inverts on every status read, a latched time-limit bit and a bit that shows whether the sector-erase queue window has closed. Which encoding is used depends on the operation mode. When no operation is reporting, the block passes array data through.

The pulse counter that raises the timeout, the command decoder and the array itself stay outside. They drive the operation mode, the busy flag, bit 7 of the byte being programmed, the window flag, the suspended-sector hit flag and a one-cycle reset-command pulse. Each read strobe produces one registered byte on the following cycle.

Top module: `flash_status_gen`

## Requirements
- R1: After reset `rd_data` is 0x00, `rd_vld` is 0, the toggle state is 0 and the timeout latch is clear.
- R2: A read strobe sampled at a clock edge makes `rd_vld` high and puts the byte on `rd_data` after that same edge. `rd_vld` stays high for exactly one cycle per strobe, and `rd_data` holds its value between reads.
- R3: With `op_mode`=00 (byte program) and `busy` high, bit 7 of a read returns the complement of `wr_poll`.
- R4: With `op_mode`=01 (chip erase) and `busy` high, or with `op_mode`=10 (sector erase), `busy` high and the window closed, bit 7 reads 0 and bit 3 reads 1.
- R5: Bit 6 inverts after every status read. An operation begins when the internal activity term (`busy`, or the sector-erase window in mode 10) rises. On that cycle the toggle state goes to 0, so the first status read after the start returns bit 6 = 0.
- R6: With `op_mode`=10 and `win_open` high, status is reported even while `busy` is low: bit 7 = 0, bit 6 toggles, bit 3 = 0.
- R7: A `timeout` pulse sets bit 5. The bit stays set, and status reporting continues, even after `busy` falls. A `clr_cmd` pulse clears it, and array data returns on later reads.
- R8: When no status is reported (`busy` low, no open window, no latched timeout, no suspended-sector hit), a read returns `arr_data` unchanged. Such a read does not advance the toggle state.
- R9: With `op_mode`=11 (erase suspended), `busy` low and `susp_hit` high, a read returns bit 7 = 1, bit 6 toggling and every other bit 0. With `susp_hit` low the same read returns `arr_data`.
- R10: With `op_mode`=11 and `busy` high (a program during suspend), the byte is encoded as in R3: bit 7 is the complement of `wr_poll`, bit 6 toggles and bit 3 is 0.
- R11: In every status byte, bits 4, 2, 1 and 0 read 0. Bit 5 reads 0 unless a timeout is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_mode | input | 2 | 00 program, 01 chip erase, 10 sector erase, 11 erase suspended |
| busy | input | 1 | Embedded operation running |
| wr_poll | input | 1 | Bit 7 of the byte being programmed |
| rd_stb | input | 1 | One-cycle read request |
| timeout | input | 1 | Time or pulse-count limit exceeded |
| win_open | input | 1 | Sector-erase queue window still open |
| susp_hit | input | 1 | Read address lies in a sector under suspended erase |
| clr_cmd | input | 1 | Reset command received |
| arr_data | input | DATA_W | Array data for the read address |
| rd_data | output | DATA_W | Returned byte |
| rd_vld | output | 1 | `rd_data` updated by a read this cycle |

## Verification
Reads are issued in each mode: program with both polarities of the written bit, chip erase, sector erase before and after its window closes, a suspended erase with and without a sector hit, and a program during suspend. Together these separate the polling rules from one another. Pairs of reads, and a re-start after a finished operation, show whether the toggle clears at a start and advances only on status reads. A timeout kept past the fall of `busy` and then cleared shows that the latch is sticky and that data pass-through returns. A reference model in the bench compares every clock.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    typedef enum logic [1:0] {
        OP_PROG       = 2'b00,
        OP_CHIP_ERASE = 2'b01,
        OP_SECT_ERASE = 2'b10,
        OP_SUSPEND    = 2'b11
    } fsg_op_e;
endpackage

// File: rtl/fsg_activity.sv
module fsg_activity
    import fsg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  fsg_op_e op,
    input  logic    busy,
    input  logic    win_open,
    output logic    act,
    output logic    start
);
    logic act_d, act_q;

    always_comb begin
        act   = busy | ((op == OP_SECT_ERASE) & win_open);
        start = act & ~act_q;
        act_d = act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act_d;
    end
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic advance,
    output logic tog_eff
);
    logic tog_d, tog_q;

    always_comb begin
        tog_eff = start ? 1'b0 : tog_q;
        tog_d   = advance ? ~tog_eff : tog_eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_d;
    end

    AST_TOG_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start && !advance |=> tog_q == 1'b0); // R5
    AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !start && !advance |=> $stable(tog_q)); // R8
endmodule

// File: rtl/fsg_timeout.sv
module fsg_timeout (
    input  logic clk,
    input  logic rst_n,
    input  logic timeout,
    input  logic clr,
    output logic to_q
);
    logic to_d;

    always_comb begin
        to_d = to_q | timeout;
        if (clr) to_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) to_q <= 1'b0;
        else        to_q <= to_d;
    end

    AST_TO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        to_q && !clr |=> to_q); // R7
    AST_TO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !to_q); // R7
endmodule

// File: rtl/fsg_encoder.sv
module fsg_encoder
    import fsg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  fsg_op_e           op,
    input  logic              act,
    input  logic              to,
    input  logic              tog,
    input  logic              win_open,
    input  logic              susp_hit,
    input  logic              wr_poll,
    input  logic              rd,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] byte_o,
    output logic              adv_o
);
    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;
    localparam int TO_BIT   = DATA_W - 3;
    localparam int WIN_BIT  = DATA_W - 5;

    logic [DATA_W-1:0] stat_byte;
    logic [DATA_W-1:0] hit_byte;
    logic              prog_like;

    always_comb begin
        prog_like = (op == OP_PROG) || (op == OP_SUSPEND);

        stat_byte           = '0;
        stat_byte[POLL_BIT] = prog_like ? ~wr_poll : 1'b0;
        stat_byte[TOG_BIT]  = tog;
        stat_byte[TO_BIT]   = to;
        unique case (op)
            OP_CHIP_ERASE: stat_byte[WIN_BIT] = 1'b1;
            OP_SECT_ERASE: stat_byte[WIN_BIT] = ~win_open;
            default:       stat_byte[WIN_BIT] = 1'b0;
        endcase

        hit_byte           = '0;
        hit_byte[POLL_BIT] = 1'b1;
        hit_byte[TOG_BIT]  = tog;

        if (act || to) begin
            byte_o = stat_byte;
            adv_o  = rd;
        end else if ((op == OP_SUSPEND) && susp_hit) begin
            byte_o = hit_byte;
            adv_o  = rd;
        end else begin
            byte_o = arr_data;
            adv_o  = 1'b0;
        end
    end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import fsg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_mode,
    input  logic              busy,
    input  logic              wr_poll,
    input  logic              rd_stb,
    input  logic              timeout,
    input  logic              win_open,
    input  logic              susp_hit,
    input  logic              clr_cmd,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_vld
);
    localparam int POLL_BIT = DATA_W - 1;
    localparam int TO_BIT   = DATA_W - 3;
    localparam int WIN_BIT  = DATA_W - 5;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              vld;
    } out_t;

    fsg_op_e           op;
    logic              act, start, tog, to_q, adv;
    logic [DATA_W-1:0] byte_w;
    out_t              out_d, out_q;

    assign op = fsg_op_e'(op_mode);

    fsg_activity u_act (
        .clk(clk), .rst_n(rst_n), .op(op), .busy(busy),
        .win_open(win_open), .act(act), .start(start)
    );

    fsg_toggle u_tog (
        .clk(clk), .rst_n(rst_n), .start(start), .advance(adv), .tog_eff(tog)
    );

    fsg_timeout u_to (
        .clk(clk), .rst_n(rst_n), .timeout(timeout), .clr(clr_cmd), .to_q(to_q)
    );

    fsg_encoder #(.DATA_W(DATA_W)) u_enc (
        .op(op), .act(act), .to(to_q), .tog(tog), .win_open(win_open),
        .susp_hit(susp_hit), .wr_poll(wr_poll), .rd(rd_stb),
        .arr_data(arr_data), .byte_o(byte_w), .adv_o(adv)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = rd_stb;
        if (rd_stb) out_d.data = byte_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rd_data = out_q.data;
    assign rd_vld  = out_q.vld;

    AST_RD_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_vld); // R2
    AST_RD_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> !rd_vld && $stable(rd_data)); // R2
    AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && busy && (op_mode == 2'b01) |=> !rd_data[POLL_BIT] && rd_data[WIN_BIT]); // R4
    AST_SUSP_HIT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && (op_mode == 2'b11) && !busy && susp_hit && !to_q
        |=> rd_data[POLL_BIT] && !rd_data[TO_BIT] && !rd_data[WIN_BIT]); // R9
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !busy && !(op_mode == 2'b10 && win_open) && !to_q
        && !(op_mode == 2'b11 && susp_hit) |=> rd_data == $past(arr_data)); // R8
endmodule

// File: tb/flash_status_gen_bench.sv
module flash_status_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] op_mode = 2'b00;
    logic       busy = 1'b0, wr_poll = 1'b0, rd_stb = 1'b0, timeout = 1'b0;
    logic       win_open = 1'b0, susp_hit = 1'b0, clr_cmd = 1'b0;
    logic [7:0] arr_data = 8'h00;
    logic [7:0] rd_data;
    logic       rd_vld;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    flash_status_gen u_flash_status_gen (
        .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .busy(busy),
        .wr_poll(wr_poll), .rd_stb(rd_stb), .timeout(timeout),
        .win_open(win_open), .susp_hit(susp_hit), .clr_cmd(clr_cmd),
        .arr_data(arr_data), .rd_data(rd_data), .rd_vld(rd_vld)
    );

    // Behavioural reference model
    int         m_tog, m_to, m_prev;
    logic [7:0] m_data;
    logic       m_vld;
    string      m_tag = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tog = 0; m_to = 0; m_prev = 0; m_data = 8'h00; m_vld = 1'b0; m_tag = "R1";
        end else begin
            int act, t;
            act = (busy || (op_mode == 2 && win_open)) ? 1 : 0;
            t = (act == 1 && m_prev == 0) ? 0 : m_tog;
            m_vld = rd_stb;
            if (rd_stb) begin
                if (act == 1 || m_to == 1) begin
                    m_data = 8'h00;
                    if (op_mode == 0 || op_mode == 3) m_data[7] = ~wr_poll;
                    m_data[6] = (t != 0);
                    m_data[5] = (m_to != 0);
                    if (op_mode == 1) m_data[3] = 1'b1;
                    if (op_mode == 2) m_data[3] = ~win_open;
                    t = 1 - t;
                    m_tag = (m_to == 1) ? "R7" : (op_mode == 3) ? "R10" :
                            (op_mode == 0) ? "R3" : (op_mode == 2 && win_open) ? "R6" : "R4";
                end else if (op_mode == 3 && susp_hit) begin
                    m_data = (t != 0) ? 8'hC0 : 8'h80;
                    t = 1 - t;
                    m_tag = "R9";
                end else begin
                    m_data = arr_data;
                    m_tag = "R8";
                end
            end
            m_tog = t;
            if (clr_cmd) m_to = 0;
            else if (timeout) m_to = 1;
            m_prev = act;
        end
    end

    task automatic chk(input logic [7:0] got, input logic [7:0] exp,
                       input logic [7:0] mask, input string tag);
        checks++;
        if ((got & mask) !== (exp & mask)) begin
            fails++;
            $display("FAIL %s: got %h expected %h (mask %h)", tag, got, exp, mask);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(rd_data, m_data, 8'hFF, {m_tag, " model data"});
            chk({7'd0, rd_vld}, {7'd0, m_vld}, 8'hFF, "R2 model valid");
        end
    end

    task automatic rd_once();
        @(negedge clk) rd_stb = 1'b1;
        @(negedge clk) rd_stb = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic b6;
        repeat (3) @(negedge clk);
        chk(rd_data, 8'h00, 8'hFF, "R1 reset data");
        chk({7'd0, rd_vld}, 8'h00, 8'hFF, "R1 reset valid");
        rst_n = 1'b1;

        @(negedge clk) arr_data = 8'h5A;
        rd_once(); chk(rd_data, 8'h5A, 8'hFF, "R8 idle pass-through");
        chk({7'd0, rd_vld}, 8'h01, 8'hFF, "R2 valid after read");
        @(negedge clk) chk({7'd0, rd_vld}, 8'h00, 8'hFF, "R2 valid one cycle");
        chk(rd_data, 8'h5A, 8'hFF, "R2 data held");

        // program
        wr_poll = 1'b1; busy = 1'b1;
        rd_once(); chk(rd_data, 8'h00, 8'hFF, "R3 complement of 1, R5 first toggle 0, R11");
        rd_once(); chk(rd_data, 8'h40, 8'hFF, "R5 toggle advanced");
        @(negedge clk) wr_poll = 1'b0;
        rd_once(); chk(rd_data, 8'h80, 8'hFF, "R3 complement of 0");
        @(negedge clk) begin busy = 1'b0; arr_data = 8'h80; end
        rd_once(); chk(rd_data, 8'h80, 8'hFF, "R8 true data after finish");

        // suspended erase
        @(negedge clk) begin op_mode = 2'b11; susp_hit = 1'b1; end
        rd_once(); chk(rd_data, 8'h80, 8'hBF, "R9 suspended sector byte");
        b6 = rd_data[6];
        @(negedge clk) begin susp_hit = 1'b0; arr_data = 8'h3C; end
        rd_once(); chk(rd_data, 8'h3C, 8'hFF, "R9 other sector data");
        @(negedge clk) susp_hit = 1'b1;
        rd_once(); chk(rd_data, {1'b1, ~b6, 6'd0}, 8'hFF, "R8 no toggle on data read");

        // program during suspend
        @(negedge clk) begin susp_hit = 1'b0; busy = 1'b1; wr_poll = 1'b1; end
        rd_once(); chk(rd_data, 8'h00, 8'hFF, "R10 suspend program first read");
        rd_once(); chk(rd_data, 8'h40, 8'hFF, "R10 suspend program toggle");
        @(negedge clk) busy = 1'b0;

        // chip erase
        @(negedge clk) begin op_mode = 2'b01; busy = 1'b1; end
        rd_once(); chk(rd_data, 8'h08, 8'hFF, "R4 chip erase busy");
        @(negedge clk) begin busy = 1'b0; arr_data = 8'hFF; end
        rd_once(); chk(rd_data, 8'hFF, 8'hFF, "R8 erased data");

        // sector erase with window
        @(negedge clk) begin op_mode = 2'b10; win_open = 1'b1; end
        rd_once(); chk(rd_data, 8'h00, 8'hFF, "R6 window open first read");
        rd_once(); chk(rd_data, 8'h40, 8'hFF, "R6 window open toggle");
        @(negedge clk) begin win_open = 1'b0; busy = 1'b1; end
        rd_once(); chk(rd_data, 8'h08, 8'hFF, "R4 sector erase running");

        // timeout
        @(negedge clk) timeout = 1'b1;
        @(negedge clk) timeout = 1'b0;
        rd_once(); chk(rd_data, 8'h28, 8'hBF, "R7 timeout bit set");
        @(negedge clk) busy = 1'b0;
        rd_once(); chk(rd_data, 8'h28, 8'hBF, "R7 timeout held after busy low");
        @(negedge clk) clr_cmd = 1'b1;
        @(negedge clk) begin clr_cmd = 1'b0; arr_data = 8'hA5; end
        rd_once(); chk(rd_data, 8'hA5, 8'hFF, "R7 cleared by reset command");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule